// File: doc/BRIEF.md
# Simulation Test-Status Control Peripheral

A small write-only register block for simulation and bring-up systems. Software on a processor uses it to halt the run, to report whether a test passed or failed, and to name the test being reported. Three 32-bit registers sit in a 16-byte decode window. A write to the halt register raises a one-cycle shutdown request. A write to the result register raises a one-cycle result strobe with a pass/fail flag. A write to the name register stores a pointer into system memory.

Once the pointer is stored, the block fetches a 16-byte name string from that address on its own read-master port. It makes four 32-bit reads in address order, places the bytes little-endian into a local buffer, and forces the final byte to zero so the string always ends in a terminator. The buffered name is presented as a flat 128-bit output.

A result write that arrives during a fetch is held back. Its strobe fires when the fetch finishes, so a result is never reported with a half-written name. Writes that fall outside the map, that are partial or unaligned, or that re-arm the fetch while it is running set a sticky error flag and have no other effect.

Top module: `sim_status_ctrl`

## Requirements
- R1: Registers are selected by byte address bits [3:2]. Index 0 (offset 0x0) is halt, index 1 (offset 0x4) is result, and index 2 (offset 0x8) is the name pointer.
- R2: Any accepted write to offset 0x0, whatever the data, makes shutdown_o high for exactly the one cycle after the write.
- R3: An accepted write to offset 0x4 while no fetch is running makes result_valid_o high for exactly the one cycle after the write. result_fail_o is 0 when the written data is zero and 1 otherwise.
- R4: An accepted write to offset 0x8 sets busy_o and mem_req_o from the next cycle. The block then issues reads at pointer+0, +4, +8 and +12, in that order. mem_addr_o stays stable while mem_req_o is high and mem_ack_i is low. busy_o falls in the cycle after the fourth mem_ack_i.
- R5: The byte read from pointer+k appears at name_o[8k+7:8k] for k = 0..14 (word bit [7:0] is the lowest address). name_o[127:120] is always zero once a fetch has completed.
- R6: A result write made while busy_o is high produces no strobe until the fetch ends. result_valid_o then pulses in the first cycle in which busy_o is low and name_o holds the new name. A later result write during the same fetch replaces the held value.
- R7: A write to offset 0xC, a write with address bits [1:0] non-zero, or a write with be_i other than 4'hF sets err_o. err_o then stays set until reset, and the write changes no register and raises no pulse.
- R8: A name-pointer write while busy_o is high sets err_o and is ignored. The running fetch completes from the original pointer.
- R9: After reset, shutdown_o, result_valid_o, result_fail_o, busy_o, mem_req_o and err_o are 0 and name_o is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address within the decode window |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables; only 4'hF is accepted |
| mem_req_o | output | 1 | Read request to system memory |
| mem_addr_o | output | MEM_AW | Read byte address |
| mem_ack_i | input | 1 | Read data valid, one pulse per request |
| mem_rdata_i | input | 32 | Read data |
| shutdown_o | output | 1 | One-cycle halt request |
| result_valid_o | output | 1 | One-cycle result strobe |
| result_fail_o | output | 1 | 1 when the last stored result is non-zero |
| busy_o | output | 1 | Name fetch in progress |
| name_o | output | 8*NAME_BYTES | Buffered name, byte 0 in the low bits |
| err_o | output | 1 | Sticky access-error flag |

## Verification
The bench uses the default parameters: a 16-byte name, a 4-bit decode window and 32-bit memory addresses. With these values the name fetch takes exactly four beats, and the fourth window slot (offset 0xC) is a real unmapped address that the error path can be driven into. The bench memory answers every request one cycle later, which lets it log the address sequence. It uses both an aligned and an unaligned pointer, so the little-endian packing and the forced terminator are checked against bytes computed from the address.

// File: rtl/sim_status_pkg.sv
package sim_status_pkg;
  typedef enum logic [1:0] {
    IDX_HALT   = 2'd0,
    IDX_RESULT = 2'd1,
    IDX_NAME   = 2'd2,
    IDX_HOLE   = 2'd3
  } reg_idx_e;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = 8 * WORD_BYTES;
endpackage

// File: rtl/sst_reg_decode.sv
module sst_reg_decode
  import sim_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic              busy_i,
  output logic              halt_wr_o,
  output logic              result_wr_o,
  output logic              name_wr_o,
  output logic              bad_wr_o
);
  logic     hi_ok;
  logic     shape_ok;
  reg_idx_e idx;

  generate
    if (ADDR_W > 4) begin : g_hi
      assign hi_ok = (addr_i[ADDR_W-1:4] == '0);
    end else begin : g_nohi
      assign hi_ok = 1'b1;
    end
  endgenerate

  assign shape_ok = hi_ok && (addr_i[1:0] == 2'b00) && (be_i == 4'hF);
  assign idx      = reg_idx_e'(addr_i[3:2]);

  always_comb begin
    halt_wr_o   = 1'b0;
    result_wr_o = 1'b0;
    name_wr_o   = 1'b0;
    bad_wr_o    = 1'b0;
    if (wr_i) begin
      if (!shape_ok) begin
        bad_wr_o = 1'b1;
      end else begin
        unique case (idx)
          IDX_HALT:   halt_wr_o   = 1'b1;
          IDX_RESULT: result_wr_o = 1'b1;
          IDX_NAME: begin
            // re-arming during a fetch is an access error
            if (busy_i) bad_wr_o  = 1'b1;
            else        name_wr_o = 1'b1;
          end
          default:    bad_wr_o    = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/sst_name_fetch.sv
module sst_name_fetch
  import sim_status_pkg::*;
#(
  parameter int unsigned NAME_BYTES = 16,
  parameter int unsigned MEM_AW     = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [WORD_W-1:0]       ptr_i,
  input  logic                    mem_ack_i,
  input  logic [WORD_W-1:0]       mem_rdata_i,
  output logic                    mem_req_o,
  output logic [MEM_AW-1:0]       mem_addr_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [8*NAME_BYTES-1:0] name_o
);
  localparam int unsigned WORDS = NAME_BYTES / WORD_BYTES;
  localparam int unsigned BW    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [BW-1:0] LAST = BW'(WORDS - 1);

  logic              busy_q;
  logic [BW-1:0]     beat_q;
  logic [MEM_AW-1:0] ptr_q;
  logic              take;

  assign take       = busy_q && mem_ack_i;
  assign done_o     = take && (beat_q == LAST);
  assign busy_o     = busy_q;
  assign mem_req_o  = busy_q;
  assign mem_addr_o = ptr_q + MEM_AW'({beat_q, 2'b00});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      ptr_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      beat_q <= '0;
      ptr_q  <= MEM_AW'(ptr_i);
    end else if (take) begin
      beat_q <= beat_q + 1'b1;
      if (beat_q == LAST) busy_q <= 1'b0;
    end
  end

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      logic [WORD_W-1:0] keep;
      if (w == WORDS - 1) begin : g_term
        assign keep = {8'h00, {(WORD_W-8){1'b1}}};
      end else begin : g_body
        assign keep = '1;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        word_q <= '0;
        else if (take && beat_q == BW'(w))  word_q <= mem_rdata_i & keep;
      end
      assign name_o[w*WORD_W +: WORD_W] = word_q;
    end
  endgenerate
endmodule

// File: rtl/sst_result_hold.sv
module sst_result_hold
  import sim_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              result_wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              fetch_busy_i,
  input  logic              fetch_done_i,
  output logic              valid_o,
  output logic              fail_o
);
  logic [WORD_W-1:0] value_q;
  logic              pend_q;
  logic              valid_q;
  logic              active;

  // a fetch finishing this cycle no longer blocks a result
  assign active = fetch_busy_i && !fetch_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_q <= '0;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (result_wr_i) value_q <= wdata_i;
      valid_q <= (result_wr_i && !active) || (pend_q && fetch_done_i);
      if (result_wr_i && active) pend_q <= 1'b1;
      else if (fetch_done_i)     pend_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign fail_o  = |value_q;
endmodule

// File: rtl/sim_status_ctrl.sv
module sim_status_ctrl
  import sim_status_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned MEM_AW     = 32,
  parameter int unsigned NAME_BYTES = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  input  logic [3:0]              be_i,
  output logic                    mem_req_o,
  output logic [MEM_AW-1:0]       mem_addr_o,
  input  logic                    mem_ack_i,
  input  logic [31:0]             mem_rdata_i,
  output logic                    shutdown_o,
  output logic                    result_valid_o,
  output logic                    result_fail_o,
  output logic                    busy_o,
  output logic [8*NAME_BYTES-1:0] name_o,
  output logic                    err_o
);
  logic halt_wr, result_wr, name_wr, bad_wr;
  logic fetch_busy, fetch_done;
  logic shut_q, err_q;

  sst_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_i        (wr_i),
    .addr_i      (addr_i),
    .be_i        (be_i),
    .busy_i      (fetch_busy),
    .halt_wr_o   (halt_wr),
    .result_wr_o (result_wr),
    .name_wr_o   (name_wr),
    .bad_wr_o    (bad_wr)
  );

  sst_name_fetch #(.NAME_BYTES(NAME_BYTES), .MEM_AW(MEM_AW)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (name_wr),
    .ptr_i       (wdata_i),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .busy_o      (fetch_busy),
    .done_o      (fetch_done),
    .name_o      (name_o)
  );

  sst_result_hold u_res (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .result_wr_i  (result_wr),
    .wdata_i      (wdata_i),
    .fetch_busy_i (fetch_busy),
    .fetch_done_i (fetch_done),
    .valid_o      (result_valid_o),
    .fail_o       (result_fail_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shut_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      shut_q <= halt_wr;
      err_q  <= err_q | bad_wr;
    end
  end

  assign shutdown_o = shut_q;
  assign err_o      = err_q;
  assign busy_o     = fetch_busy;
endmodule

// File: rtl/sim_status_ctrl_chk.sv
module sim_status_ctrl_chk #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned MEM_AW     = 32,
  parameter int unsigned NAME_BYTES = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [3:0]              be_i,
  input logic                    mem_req_o,
  input logic [MEM_AW-1:0]       mem_addr_o,
  input logic                    mem_ack_i,
  input logic                    shutdown_o,
  input logic                    result_valid_o,
  input logic                    busy_o,
  input logic [8*NAME_BYTES-1:0] name_o,
  input logic                    err_o
);
  p_halt_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && be_i == 4'hF && addr_i == '0) |=> shutdown_o);

  p_halt_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> !shutdown_o);

  p_valid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_term_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (name_o[8*NAME_BYTES-1 -: 8] == 8'h00));

  p_valid_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> !busy_o);

  p_partial_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && be_i != 4'hF) |=> err_o);

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind sim_status_ctrl sim_status_ctrl_chk #(
  .ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .NAME_BYTES(NAME_BYTES)
) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_i           (wr_i),
  .addr_i         (addr_i),
  .be_i           (be_i),
  .mem_req_o      (mem_req_o),
  .mem_addr_o     (mem_addr_o),
  .mem_ack_i      (mem_ack_i),
  .shutdown_o     (shutdown_o),
  .result_valid_o (result_valid_o),
  .busy_o         (busy_o),
  .name_o         (name_o),
  .err_o          (err_o)
);

// File: tb/sim_status_ctrl_tb_top.sv
module sim_status_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  ADDR_W = 4;
  localparam int  MEM_AW = 32;
  localparam int  NB     = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [3:0]        be_i = 4'hF;
  logic              mem_req_o;
  logic [MEM_AW-1:0] mem_addr_o;
  logic              mem_ack_i = 1'b0;
  logic [31:0]       mem_rdata_i = '0;
  logic              shutdown_o, result_valid_o, result_fail_o, busy_o, err_o;
  logic [8*NB-1:0]   name_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sim_status_ctrl #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .NAME_BYTES(NB)) dut_i (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .be_i,
    .mem_req_o, .mem_addr_o, .mem_ack_i, .mem_rdata_i,
    .shutdown_o, .result_valid_o, .result_fail_o, .busy_o, .name_o, .err_o
  );

  // memory model: byte at address a is a function of a
  function automatic logic [7:0] mem_byte(logic [31:0] a);
    return (a[7:0] ^ a[15:8]) + 8'h41;
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {mem_byte(a + 3), mem_byte(a + 2), mem_byte(a + 1), mem_byte(a)};
  endfunction

  function automatic logic [8*NB-1:0] exp_name(logic [31:0] p);
    logic [8*NB-1:0] n = '0;
    for (int k = 0; k < NB - 1; k++) n[8*k +: 8] = mem_byte(p + k);
    return n;
  endfunction

  logic [31:0] seen_addr [64];
  int          seen_n = 0;

  always @(posedge clk_i) begin
    if (mem_req_o && !mem_ack_i) begin
      mem_ack_i   <= 1'b1;
      mem_rdata_i <= mem_word(mem_addr_o);
      seen_addr[seen_n % 64] <= mem_addr_o;
      seen_n <= seen_n + 1;
    end else begin
      mem_ack_i <= 1'b0;
    end
  end

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [ADDR_W-1:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d; be_i = be;
    @(negedge clk_i);
    wr_i = 1'b0; be_i = 4'hF;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // waits for fetch end; counts result pulses and checks the name at each
  task automatic wait_idle(logic [31:0] p, output int pulses);
    pulses = 0;
    for (int i = 0; i < 40 && busy_o; i++) begin
      @(negedge clk_i);
      if (result_valid_o) begin
        pulses++;
        check("R6 busy at strobe", busy_o, 0);
        check("R6 name at strobe", name_o, exp_name(p));
      end
    end
    check("R4 fetch ends", busy_o, 0);
  endtask

  // {addr, data, be, shut, valid, fail, err}
  localparam int NV = 10;
  localparam logic [43:0] VEC [NV] = '{
    {4'h0, 32'h0000_0000, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'h0, 32'hFFFF_FFFF, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'h4, 32'h0000_0000, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'h4, 32'h0000_0001, 4'hF, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'h4, 32'h8000_0000, 4'hF, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'h4, 32'h0000_0000, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'h1, 32'h0000_0009, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'hC, 32'h0000_0005, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'h4, 32'h0000_0007, 4'h3, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'h0, 32'h0000_0000, 4'h1, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  initial begin
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base, pulses;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9 reset state
    check("R9 shutdown", shutdown_o, 0);
    check("R9 valid", result_valid_o, 0);
    check("R9 fail", result_fail_o, 0);
    check("R9 busy", busy_o, 0);
    check("R9 req", mem_req_o, 0);
    check("R9 err", err_o, 0);
    check("R9 name", name_o, 0);

    // R1 R2 R3 R7 vector walk
    for (int v = 0; v < NV; v++) begin
      logic [43:0] e = VEC[v];
      do_write(e[43:40], e[39:8], e[7:4]);
      check("R2 shutdown pulse", shutdown_o, e[3]);
      check("R3 result strobe", result_valid_o, e[2]);
      check("R3 fail flag", result_fail_o, e[1]);
      check("R7 error flag", err_o, e[0]);
      @(negedge clk_i);
      check("R2 R3 one cycle", {shutdown_o, result_valid_o}, 0);
    end

    do_reset();
    check("R9 err cleared", err_o, 0);

    // R4 R5 aligned fetch
    base = seen_n;
    do_write(4'h8, 32'h0000_0100, 4'hF);
    check("R4 busy set", busy_o, 1);
    check("R4 req set", mem_req_o, 1);
    check("R4 first addr", mem_addr_o, 32'h100);
    wait_idle(32'h100, pulses);
    check("R4 beat count", seen_n - base, 4);
    for (int k = 0; k < 4; k++)
      check("R4 addr order", seen_addr[(base + k) % 64], 32'h100 + 4 * k);
    check("R5 name aligned", name_o, exp_name(32'h100));
    check("R5 terminator", name_o[127:120], 0);
    check("R3 no stray strobe", pulses, 0);

    // R5 unaligned pointer
    do_write(4'h8, 32'h0000_2A03, 4'hF);
    wait_idle(32'h2A03, pulses);
    check("R5 name unaligned", name_o, exp_name(32'h2A03));

    // R6 held result, overwritten while pending
    do_write(4'h8, 32'h0000_0340, 4'hF);
    do_write(4'h4, 32'h0000_0005, 4'hF);
    check("R6 no early strobe", result_valid_o, 0);
    do_write(4'h4, 32'h0000_0000, 4'hF);
    check("R6 still held", result_valid_o, 0);
    wait_idle(32'h340, pulses);
    if (result_valid_o === 1'b0) begin
      @(negedge clk_i);
      if (result_valid_o) begin
        pulses++;
        check("R6 name at strobe", name_o, exp_name(32'h340));
      end
    end
    check("R6 one strobe", pulses, 1);
    check("R6 latest value", result_fail_o, 0);
    check("R7 no error yet", err_o, 0);

    // R8 re-arm while busy
    base = seen_n;
    do_write(4'h8, 32'h0000_0500, 4'hF);
    do_write(4'h8, 32'h0000_0700, 4'hF);
    check("R8 error set", err_o, 1);
    wait_idle(32'h500, pulses);
    check("R8 beat count", seen_n - base, 4);
    check("R8 last addr", seen_addr[(base + 3) % 64], 32'h50C);
    check("R8 name kept", name_o, exp_name(32'h500));

    // R9 reset clears buffer
    do_reset();
    check("R9 name cleared", name_o, 0);
    check("R9 err cleared again", err_o, 0);
    check("R9 fail cleared", result_fail_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule